// File: doc/BRIEF.md
# Indexed Byte Port With Lock Windows

This block places a large byte-addressed space behind a four-byte port. Two port offsets load the low and high bytes of a 16-bit pointer register. The data offset reads or writes the byte the pointer selects, through a simple synchronous memory interface. After every data write the pointer returns to zero. Reads at the data offset leave the pointer unchanged, so software can poll one location repeatedly.

Two lock bits each guard a fixed 16-byte window. Lock 0 guards 0x20–0x2F and lock 1 guards 0x30–0x3F. Each lock request flips one bit. A data access that falls in a locked window, or at or above the memory size, does not reach the memory side. A refused read returns 0xFF and a refused write is dropped.

Read results come from a three-state sequencer. The states are ST_IDLE (nothing to return), ST_FETCH (return the byte the memory delivers) and ST_FILL (return 0xFF). From any state, a granted data read leads to ST_FETCH, a refused or non-data read leads to ST_FILL, and a cycle with no read leads back to ST_IDLE. The memory has one cycle of read latency. Read data therefore appears, with `port_rvalid`, in the cycle after the read is presented.

Top module: `idx_byte_port`

## Requirements
- R1: A port write at offset 0 loads the low pointer byte and keeps the high byte. The new pointer is visible on `mem_addr` in the next cycle.
- R2: A port write at offset 1 loads the high pointer byte and keeps the low byte.
- R3: A port write at offset 3 drives `mem_we` in that cycle, with `mem_addr` equal to the pointer and `mem_wdata` equal to the port data. The pointer is 0x0000 in the next cycle, even if the write was refused.
- R4: A port read at offset 3 drives `mem_re` in that cycle. In the next cycle `port_rvalid` is 1 and `port_rdata` carries the memory byte. The read leaves the pointer unchanged.
- R5: A port read at offset 0, 1 or 2 does not drive `mem_re`. In the next cycle `port_rvalid` is 1 and `port_rdata` is 0xFF.
- R6: A port write at offset 2 has no effect: the pointer is unchanged and `mem_we` stays 0.
- R7: While lock bit 0 is 1, data accesses to 0x20–0x2F are refused. While lock bit 1 is 1, data accesses to 0x30–0x3F are refused. A refused write never asserts `mem_we`, and a refused read returns 0xFF.
- R8: A cycle with `lock_req` high flips lock bit `lock_sel`. A data access in that same cycle is judged against the lock value from before the flip.
- R9: Data accesses with the pointer at or above MEM_SIZE (default 1024) are refused in the same way as locked ones.
- R10: When `port_wr` and `port_rd` are both high, the write takes effect and the read is ignored: `port_rvalid` stays 0 in the next cycle.
- R11: Reset clears the pointer to 0x0000 and both lock bits to 0, and puts the sequencer in ST_IDLE.
- R12: `port_rdata` is 0x00 whenever `port_rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_wr | input | 1 | Port byte write strobe |
| port_rd | input | 1 | Port byte read strobe |
| port_off | input | 2 | Port offset: 0 = pointer low, 1 = pointer high, 3 = data |
| port_wdata | input | 8 | Port write byte |
| lock_req | input | 1 | Flip the selected lock bit |
| lock_sel | input | 1 | Lock bit selected for flipping |
| port_rdata | output | 8 | Port read byte, valid with `port_rvalid` |
| port_rvalid | output | 1 | Read result present this cycle |
| mem_addr | output | 16 | Memory address, equal to the pointer |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read byte, one cycle after `mem_re` |

## Verification
A lock flip and a data access can arrive in the same cycle. The access must be judged by the lock value from before the flip. The bench provokes this case in both directions: it writes into a window in the cycle that locks it, and it reads from a locked window in the cycle that unlocks it. It then judges the outcome by follow-up reads against its own model. A simultaneous port write and port read is also driven, and the bench confirms that no read result appears while the write and the pointer clear still take effect.

// File: rtl/idx_port_pkg.sv
package idx_port_pkg;

    localparam logic [1:0] OFF_PTR_LO = 2'd0;
    localparam logic [1:0] OFF_PTR_HI = 2'd1;
    localparam logic [1:0] OFF_DATA   = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_FILL  = 2'd2
    } rd_state_e;

endpackage

// File: rtl/idx_port_index.sv
module idx_port_index #(
    parameter int IDX_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              clr,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [IDX_W-1:0]  idx_q
);
    localparam int HI_W = IDX_W - BYTE_W;

    logic [IDX_W-1:0] idx_d;

    always_comb begin
        idx_d = idx_q;
        if (clr) begin
            idx_d = '0;
        end else if (ld_lo) begin
            idx_d[BYTE_W-1:0] = byte_in;
        end else if (ld_hi) begin
            idx_d[IDX_W-1:BYTE_W] = byte_in[HI_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end
endmodule

// File: rtl/idx_port_locks.sv
module idx_port_locks #(
    parameter int IDX_W     = 16,
    parameter int NUM_LOCKS = 2,
    parameter int LOCK_BASE = 32,
    parameter int WIN_SZ    = 16,
    parameter int MEM_SIZE  = 1024,
    localparam int SEL_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tgl_req,
    input  logic [SEL_W-1:0]     tgl_sel,
    input  logic [IDX_W-1:0]     idx,
    output logic [NUM_LOCKS-1:0] lock_q,
    output logic                 refuse
);
    logic [NUM_LOCKS-1:0] win_hit;
    logic [31:0]          idx_ext;
    logic                 beyond;

    assign idx_ext = 32'(idx);
    assign beyond  = idx_ext >= 32'(MEM_SIZE);

    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_win
        localparam int WLO = LOCK_BASE + g * WIN_SZ;
        localparam int WHI = WLO + WIN_SZ;

        assign win_hit[g] = lock_q[g] && (idx_ext >= 32'(WLO)) && (idx_ext < 32'(WHI));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lock_q[g] <= 1'b0;
            end else if (tgl_req && (tgl_sel == SEL_W'(g))) begin
                lock_q[g] <= ~lock_q[g];
            end
        end
    end

    assign refuse = beyond || (|win_hit);
endmodule

// File: rtl/idx_port_rdseq.sv
module idx_port_rdseq
    import idx_port_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic              rd_ok,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              rvalid,
    output logic [BYTE_W-1:0] rdata
);
    rd_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        if (!rd_go)     st_d = ST_IDLE;
        else if (rd_ok) st_d = ST_FETCH;
        else            st_d = ST_FILL;
    end

    always_comb begin
        rvalid = 1'b0;
        rdata  = '0;
        unique case (st_q)
            ST_IDLE: begin
                rvalid = 1'b0;
                rdata  = '0;
            end
            ST_FETCH: begin
                rvalid = 1'b1;
                rdata  = mem_rdata;
            end
            ST_FILL: begin
                rvalid = 1'b1;
                rdata  = '1;
            end
            default: begin
                rvalid = 1'b0;
                rdata  = '0;
            end
        endcase
    end
endmodule

// File: rtl/idx_byte_port.sv
module idx_byte_port
    import idx_port_pkg::*;
#(
    parameter int IDX_W     = 16,
    parameter int BYTE_W    = 8,
    parameter int NUM_LOCKS = 2,
    parameter int LOCK_BASE = 32,
    parameter int WIN_SZ    = 16,
    parameter int MEM_SIZE  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_wr,
    input  logic              port_rd,
    input  logic [1:0]        port_off,
    input  logic [BYTE_W-1:0] port_wdata,
    input  logic              lock_req,
    input  logic              lock_sel,
    output logic [BYTE_W-1:0] port_rdata,
    output logic              port_rvalid,
    output logic [IDX_W-1:0]  mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [BYTE_W-1:0] mem_rdata
);
    localparam int SEL_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1;

    logic                 wr_lo, wr_hi, wr_data;
    logic                 rd_go, rd_data, refuse;
    logic [IDX_W-1:0]     idx_q;
    logic [NUM_LOCKS-1:0] lock_q;

    assign wr_lo   = port_wr && (port_off == OFF_PTR_LO);
    assign wr_hi   = port_wr && (port_off == OFF_PTR_HI);
    assign wr_data = port_wr && (port_off == OFF_DATA);
    assign rd_go   = port_rd && !port_wr;
    assign rd_data = rd_go && (port_off == OFF_DATA);

    idx_port_index #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lo   (wr_lo),
        .ld_hi   (wr_hi),
        .clr     (wr_data),
        .byte_in (port_wdata),
        .idx_q   (idx_q)
    );

    idx_port_locks #(
        .IDX_W(IDX_W), .NUM_LOCKS(NUM_LOCKS), .LOCK_BASE(LOCK_BASE),
        .WIN_SZ(WIN_SZ), .MEM_SIZE(MEM_SIZE)
    ) u_locks (
        .clk     (clk),
        .rst_n   (rst_n),
        .tgl_req (lock_req),
        .tgl_sel (SEL_W'(lock_sel)),
        .idx     (idx_q),
        .lock_q  (lock_q),
        .refuse  (refuse)
    );

    idx_port_rdseq #(.BYTE_W(BYTE_W)) u_rdseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_go     (rd_go),
        .rd_ok     (rd_data && !refuse),
        .mem_rdata (mem_rdata),
        .rvalid    (port_rvalid),
        .rdata     (port_rdata)
    );

    assign mem_addr  = idx_q;
    assign mem_wdata = port_wdata;
    assign mem_we    = wr_data && !refuse;
    assign mem_re    = rd_data && !refuse;
endmodule

// File: rtl/idx_byte_port_chk.sv
module idx_byte_port_chk #(
    parameter int IDX_W     = 16,
    parameter int BYTE_W    = 8,
    parameter int NUM_LOCKS = 2,
    parameter int LOCK_BASE = 32,
    parameter int WIN_SZ    = 16,
    parameter int MEM_SIZE  = 1024
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 port_wr,
    input logic                 port_rd,
    input logic [1:0]           port_off,
    input logic                 lock_req,
    input logic                 lock_sel,
    input logic [BYTE_W-1:0]    port_rdata,
    input logic                 port_rvalid,
    input logic [IDX_W-1:0]     mem_addr,
    input logic                 mem_we,
    input logic                 mem_re,
    input logic [NUM_LOCKS-1:0] lock_q
);
    p_ptr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && port_off == 2'd3) |=> (mem_addr == '0));

    p_read_keeps_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && !port_wr) |=> $stable(mem_addr));

    p_read_answers_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && !port_wr) |=> port_rvalid);

    p_other_off_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && !port_wr && port_off != 2'd3) |=> (port_rvalid && port_rdata == '1));

    p_off2_write_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && port_off == 2'd2) |=> $stable(mem_addr));

    p_range_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (32'(mem_addr) < 32'(MEM_SIZE)));

    p_wr_beats_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && port_rd && !$past(port_rd && !port_wr)) |=> !port_rvalid);

    p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !port_rvalid |-> (port_rdata == '0));

    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lk
        localparam int WLO = LOCK_BASE + g * WIN_SZ;

        p_lock_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_req && 32'(lock_sel) == g) |=> (lock_q[g] != $past(lock_q[g])));

        p_lock_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_q[g] && 32'(mem_addr) >= 32'(WLO) && 32'(mem_addr) < 32'(WLO + WIN_SZ))
                |-> !(mem_we || mem_re));
    end
endmodule

bind idx_byte_port idx_byte_port_chk #(
    .IDX_W(IDX_W), .BYTE_W(BYTE_W), .NUM_LOCKS(NUM_LOCKS),
    .LOCK_BASE(LOCK_BASE), .WIN_SZ(WIN_SZ), .MEM_SIZE(MEM_SIZE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_rd(port_rd),
    .port_off(port_off), .lock_req(lock_req), .lock_sel(lock_sel),
    .port_rdata(port_rdata), .port_rvalid(port_rvalid), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .lock_q(lock_q)
);

// File: tb/idx_byte_port_tb_top.sv
`timescale 1ns/1ps
module idx_byte_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_wr = 1'b0, port_rd = 1'b0, lock_req = 1'b0, lock_sel = 1'b0;
    logic [1:0]  port_off = 2'd0;
    logic [7:0]  port_wdata = 8'd0;
    logic [7:0]  port_rdata, mem_wdata, mem_rdata;
    logic        port_rvalid, mem_we, mem_re;
    logic [15:0] mem_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] bmem    [0:1023];
    logic [7:0] exp_mem [0:1023];
    logic [7:0] mem_q = 8'd0;
    logic [15:0] s_idx = 16'd0;
    logic [1:0]  s_lock = 2'b00;
    logic [7:0]  exp_q [$];
    logic        last_we, last_re;
    logic [15:0] last_addr;
    logic [7:0]  last_wdata;

    always #2.5 clk = ~clk;

    idx_byte_port dut_i (
        .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_rd(port_rd),
        .port_off(port_off), .port_wdata(port_wdata), .lock_req(lock_req),
        .lock_sel(lock_sel), .port_rdata(port_rdata), .port_rvalid(port_rvalid),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem_q;

    always @(posedge clk) begin
        if (mem_we) bmem[mem_addr[9:0]] <= mem_wdata;
        if (mem_re) mem_q <= bmem[mem_addr[9:0]];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit refused(input logic [15:0] i);
        return (i >= 16'd1024) ||
               (s_lock[0] && i >= 16'h20 && i <= 16'h2F) ||
               (s_lock[1] && i >= 16'h30 && i <= 16'h3F);
    endfunction

    // Monitor: pops one expected read byte per returned result.
    always @(negedge clk) begin
        if (rst_n && port_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected read result", port_rdata, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(port_rdata == e, "R4/R5/R7/R9 read data", port_rdata, e);
            end
        end
    end

    // Driver: one port cycle, starting and ending at a falling edge.
    task automatic op(input bit wr, input bit rd, input logic [1:0] off,
                      input logic [7:0] d, input bit lreq, input bit lsel);
        bit rf;
        port_wr = wr; port_rd = rd; port_off = off; port_wdata = d;
        lock_req = lreq; lock_sel = lsel;
        #1;
        rf = refused(s_idx);
        last_we = mem_we; last_re = mem_re; last_addr = mem_addr; last_wdata = mem_wdata;
        if (rd && !wr) exp_q.push_back((off == 2'd3 && !rf) ? exp_mem[s_idx[9:0]] : 8'hFF);
        @(posedge clk);
        if (wr) begin
            case (off)
                2'd0: s_idx[7:0] = d;
                2'd1: s_idx[15:8] = d;
                2'd3: begin
                    if (!rf) exp_mem[s_idx[9:0]] = d;
                    s_idx = 16'd0;
                end
                default: ;
            endcase
        end
        if (lreq) s_lock[lsel] = ~s_lock[lsel];
        @(negedge clk);
        port_wr = 1'b0; port_rd = 1'b0; lock_req = 1'b0;
    endtask

    task automatic set_ptr(input logic [15:0] p);
        op(1'b1, 1'b0, 2'd0, p[7:0], 1'b0, 1'b0);
        op(1'b1, 1'b0, 2'd1, p[15:8], 1'b0, 1'b0);
    endtask

    task automatic rd3();
        op(1'b0, 1'b1, 2'd3, 8'd0, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            bmem[i] = 8'((i * 7 + 3) & 8'hFF);
            exp_mem[i] = 8'((i * 7 + 3) & 8'hFF);
        end
        repeat (3) @(negedge clk);
        check(mem_addr == 16'd0, "R11 pointer in reset", mem_addr, 0);
        check(port_rvalid == 1'b0, "R11 rvalid in reset", port_rvalid, 0);
        check(port_rdata == 8'd0, "R12 rdata idle", port_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: locks clear after reset, a window access goes through
        set_ptr(16'h0024); rd3();
        check(last_re == 1'b1, "R11 locks clear after reset", last_re, 1);

        // R1 / R2 pointer loads
        op(1'b1, 1'b0, 2'd0, 8'h05, 1'b0, 1'b0);
        op(1'b1, 1'b0, 2'd1, 8'h02, 1'b0, 1'b0);
        check(mem_addr == 16'h0205, "R2 high byte load", mem_addr, 16'h0205);
        op(1'b1, 1'b0, 2'd0, 8'h10, 1'b0, 1'b0);
        check(mem_addr == 16'h0210, "R1 low byte load keeps high", mem_addr, 16'h0210);
        op(1'b1, 1'b0, 2'd1, 8'h00, 1'b0, 1'b0);
        check(mem_addr == 16'h0010, "R2 high byte load keeps low", mem_addr, 16'h0010);

        // R3 data write and pointer clear
        op(1'b1, 1'b0, 2'd3, 8'hA5, 1'b0, 1'b0);
        check(last_we && last_addr == 16'h0010 && last_wdata == 8'hA5,
              "R3 write strobe", {last_we, last_addr, last_wdata}, {1'b1, 16'h0010, 8'hA5});
        check(mem_addr == 16'h0000, "R3 pointer cleared", mem_addr, 0);

        // R4 reads, repeated, pointer held
        set_ptr(16'h0010); rd3(); rd3();
        check(mem_addr == 16'h0010, "R4 pointer kept after reads", mem_addr, 16'h0010);
        set_ptr(16'h03FF); rd3();

        // R5 reads at non-data offsets
        op(1'b0, 1'b1, 2'd0, 8'd0, 1'b0, 1'b0);
        check(last_re == 1'b0, "R5 no mem read at offset 0", last_re, 0);
        op(1'b0, 1'b1, 2'd1, 8'd0, 1'b0, 1'b0);
        op(1'b0, 1'b1, 2'd2, 8'd0, 1'b0, 1'b0);

        // R6 offset 2 write ignored
        set_ptr(16'h0123);
        op(1'b1, 1'b0, 2'd2, 8'h77, 1'b0, 1'b0);
        check(last_we == 1'b0, "R6 no mem write at offset 2", last_we, 0);
        check(mem_addr == 16'h0123, "R6 pointer unchanged", mem_addr, 16'h0123);

        // R7 lock windows
        op(1'b0, 1'b0, 2'd0, 8'd0, 1'b1, 1'b0);
        set_ptr(16'h0025);
        op(1'b1, 1'b0, 2'd3, 8'h11, 1'b0, 1'b0);
        check(last_we == 1'b0, "R7 locked write dropped", last_we, 0);
        set_ptr(16'h0025); rd3();
        check(last_re == 1'b0, "R7 locked read no mem read", last_re, 0);
        set_ptr(16'h002F); rd3();
        set_ptr(16'h0030); rd3();
        check(last_re == 1'b1, "R7 0x30 open under lock 0", last_re, 1);
        op(1'b0, 1'b0, 2'd0, 8'd0, 1'b1, 1'b0);
        set_ptr(16'h0025); rd3();
        op(1'b0, 1'b0, 2'd0, 8'd0, 1'b1, 1'b1);
        set_ptr(16'h003A);
        op(1'b1, 1'b0, 2'd3, 8'h22, 1'b0, 1'b0);
        check(last_we == 1'b0, "R7 lock 1 write dropped", last_we, 0);
        set_ptr(16'h003A); rd3();
        set_ptr(16'h0025); rd3();
        set_ptr(16'h0040); rd3();
        op(1'b0, 1'b0, 2'd0, 8'd0, 1'b1, 1'b1);
        set_ptr(16'h003A); rd3();

        // R8 same-cycle flip and access
        set_ptr(16'h0028);
        op(1'b1, 1'b0, 2'd3, 8'h5A, 1'b1, 1'b0);
        check(last_we == 1'b1, "R8 write uses lock before flip", last_we, 1);
        set_ptr(16'h0028);
        op(1'b0, 1'b1, 2'd3, 8'd0, 1'b1, 1'b0);
        check(last_re == 1'b0, "R8 read uses lock before flip", last_re, 0);
        rd3();
        check(last_re == 1'b1, "R8 unlocked after flip", last_re, 1);

        // R9 beyond memory size
        set_ptr(16'h0400);
        op(1'b1, 1'b0, 2'd3, 8'h99, 1'b0, 1'b0);
        check(last_we == 1'b0, "R9 write beyond size dropped", last_we, 0);
        set_ptr(16'h0400); rd3();
        set_ptr(16'hFFFF); rd3();

        // R10 write and read together
        set_ptr(16'h0041);
        op(1'b1, 1'b1, 2'd3, 8'h3C, 1'b0, 1'b0);
        check(port_rvalid == 1'b0, "R10 read ignored", port_rvalid, 0);
        check(mem_addr == 16'h0000, "R10 write cleared pointer", mem_addr, 0);
        set_ptr(16'h0041); rd3();
        check(port_rvalid == 1'b1, "R4 rvalid after read", port_rvalid, 1);
        @(negedge clk);
        check(port_rdata == 8'd0 && !port_rvalid, "R12 rdata zero when idle", port_rdata, 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4 all reads answered", exp_q.size(), 0);
        finish_run();
    end

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end
endmodule